// File: doc/BRIEF.md
# Programmable Receive Sample Delay

This block sits beside the receive shifter of a serial-peripheral master and moves the point at which the serial input line is sampled. The timing logic gives a one-cycle sample tick at the nominal sampling instant. The block holds that tick back by a programmed number of serial-clock cycles and then captures the input line. This lets the master make up for the round-trip delay through pads, board traces and the slave's output path. The block produces the delayed tick and the captured bit, and the receive shifter consumes both.

An 8-bit configuration field sets the delay. Software can change it only while the controller is disabled. The delay applies only in master mode; in slave mode the nominal tick is used unchanged. A programmed value larger than the depth of the internal delay line gives zero delay, but the register still reads back the value that was written. The tick and the bit are plain strobed outputs with no back-pressure: the receive shifter must take the bit in the cycle its tick is high, because the block does not wait for it.

Top module: `rx_sample_delay`

## Requirements
- R1: After reset the configuration readback is 0, the delayed tick is low and the captured bit is 0. The delay field is bits 7:0 of the 32-bit write word, and readback bits 31:8 are always 0.
- R2: A configuration write made while the controller enable is high leaves the stored delay and its readback unchanged.
- R3: A write of any 8-bit value, including one above the line depth, reads back exactly as written.
- R4: In master mode with a stored delay d in 1..DEPTH (default DEPTH = 4), a tick on `sample_tick` in cycle t gives `dly_tick` high in cycle t+1+d, and in no other cycle of that window.
- R5: In master mode with a stored delay of 0, a tick in cycle t gives `dly_tick` high in cycle t+1.
- R6: In slave mode (`master_mode` low) the stored delay is ignored and a tick in cycle t gives `dly_tick` high in cycle t+1.
- R7: A stored value above DEPTH gives zero delay. A stored value equal to DEPTH gives the full delay of DEPTH cycles.
- R8: When `dly_tick` goes high in cycle t+1+d, `rx_bit` holds the value `rxd` had in cycle t+d. `rx_bit` changes only together with a delayed tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_enable | input | 1 | Controller enable; while high, configuration writes are blocked |
| master_mode | input | 1 | High: master mode, delay applied; low: slave mode |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Write data; bits 7:0 carry the delay value |
| cfg_rdata | output | 32 | Readback of the stored delay value, upper bits zero |
| sample_tick | input | 1 | Nominal sample tick, one cycle wide |
| rxd | input | 1 | Serial receive input |
| dly_tick | output | 1 | Registered delayed sample tick |
| rx_bit | output | 1 | Registered captured receive bit |

## Verification
The assertions check on every cycle that blocked writes leave the stored value alone and that the readback's upper bits stay zero. They also check that slave mode and out-of-range values pass the tick through after one register stage, that a delayed tick always carries the previous cycle's input value, and that the captured bit never moves without a tick. The exact cycle distance for each in-range delay, including the full-depth setting, can only be shown by the bench's scenarios. So can the readback of out-of-range values, and the fact that a locked write leaves the timing unchanged. Each scenario fences the correct input value with its complement on the cycles around the sampling cycle, so a capture one cycle early or late shows up as a wrong bit.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  localparam int BUS_W = 32;
  localparam int DLY_W = 8;
  typedef logic [DLY_W-1:0] dly_t;
endpackage

// File: rtl/rsd_cfg_reg.sv
module rsd_cfg_reg
  import rsd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_enable,
  input  logic             cfg_wr,
  input  logic [BUS_W-1:0] cfg_wdata,
  output dly_t             dly_value,
  output logic [BUS_W-1:0] cfg_rdata
);
  dly_t dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
    end else if (cfg_wr && !ctrl_enable) begin
      dly_q <= cfg_wdata[DLY_W-1:0];
    end
  end

  assign dly_value = dly_q;
  assign cfg_rdata = {{(BUS_W-DLY_W){1'b0}}, dly_q};

  // R2: a write while enabled must not move the stored value
  p_wr_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_enable && cfg_wr) |=> $stable(dly_q));
endmodule

// File: rtl/rsd_delay_line.sv
module rsd_delay_line
  import rsd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic master_mode,
  input  dly_t dly_value,
  output logic tap
);
  localparam int SEL_W = (DEPTH < 1) ? 1 : $clog2(DEPTH + 1);

  logic [DEPTH:0]   line;
  logic             in_range;
  logic [SEL_W-1:0] sel;

  assign line[0] = sample_tick;

  for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line[g] <= 1'b0;
      end else begin
        line[g] <= line[g-1];
      end
    end
  end

  assign in_range = ({{(32-DLY_W){1'b0}}, dly_value} <= 32'(DEPTH));

  always_comb begin
    if (master_mode && in_range) begin
      sel = dly_value[SEL_W-1:0];
    end else begin
      sel = '0;
    end
  end

  always_comb begin
    tap = 1'b0;
    for (int i = 0; i <= DEPTH; i++) begin
      if (sel == SEL_W'(i)) begin
        tap = line[i];
      end
    end
  end
endmodule

// File: rtl/rsd_capture.sv
module rsd_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic tap,
  input  logic rxd,
  output logic dly_tick,
  output logic rx_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_tick <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      dly_tick <= tap;
      if (tap) begin
        rx_bit <= rxd;
      end
    end
  end

  // R8: a delayed tick carries the input of the cycle before it
  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dly_tick |-> (rx_bit == $past(rxd)));

  // R8: the captured bit only moves together with a tick
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit) |-> dly_tick);
endmodule

// File: rtl/rx_sample_delay.sv
module rx_sample_delay
  import rsd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_enable,
  input  logic        master_mode,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        sample_tick,
  input  logic        rxd,
  output logic        dly_tick,
  output logic        rx_bit
);
  dly_t dly_value;
  logic tap;

  rsd_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_enable(ctrl_enable),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .dly_value  (dly_value),
    .cfg_rdata  (cfg_rdata)
  );

  rsd_delay_line #(.DEPTH(DEPTH)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_tick(sample_tick),
    .master_mode(master_mode),
    .dly_value  (dly_value),
    .tap        (tap)
  );

  rsd_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .tap     (tap),
    .rxd     (rxd),
    .dly_tick(dly_tick),
    .rx_bit  (rx_bit)
  );

  // R1: upper readback bits stay clear
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:8] == 24'd0);

  // R6: slave mode passes the tick after one register stage
  p_slave_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && sample_tick) |=> dly_tick);

  // R7: out-of-range value falls back to zero delay
  p_overrange_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && ({24'd0, dly_value} > 32'(DEPTH)) && sample_tick) |=> dly_tick);
endmodule

// File: tb/tb_rx_sample_delay.sv
`timescale 1ns/1ps
module tb_rx_sample_delay;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_enable = 1'b0;
  logic        master_mode = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        sample_tick = 1'b0;
  logic        rxd = 1'b0;
  logic        dly_tick;
  logic        rx_bit;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  rx_sample_delay #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .master_mode(master_mode),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sample_tick(sample_tick), .rxd(rxd), .dly_tick(dly_tick), .rx_bit(rx_bit)
  );

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
    cfg_wdata = '0;
  endtask

  // Tick in cycle 0; rxd equals b only in cycle exp_d, complement elsewhere.
  task automatic run_delay(string req, int exp_d, logic b);
    int seen = -1;
    int hits = 0;
    logic got = 1'b0;
    for (int k = 0; k <= DEPTH + 3; k++) begin
      @(negedge clk);
      if (k > 0 && dly_tick) begin
        hits++;
        if (seen < 0) begin
          seen = k - 1;
          got = rx_bit;
        end
      end
      sample_tick = (k == 0);
      rxd = (k == exp_d) ? b : ~b;
    end
    @(negedge clk);
    sample_tick = 1'b0;
    check({req, " delay"}, seen, exp_d);
    check({req, " single tick"}, hits, 1);
    check({req, " captured bit"}, got, b);
  endtask

  task automatic t_reset_r1;
    @(negedge clk);
    check("R1 reset readback", cfg_rdata, 0);
    check("R1 reset tick", dly_tick, 0);
    check("R1 reset bit", rx_bit, 0);
  endtask

  task automatic t_field_r1;
    cfg_write(32'hA5C3_7E02);
    check("R1 field bits 7:0 only", cfg_rdata, 2);
  endtask

  task automatic t_master_delays_r4;
    for (int d = 1; d <= DEPTH; d++) begin
      cfg_write(32'(d));
      run_delay((d == DEPTH) ? "R7 full depth" : "R4", d, d[0]);
    end
  endtask

  task automatic t_zero_r5;
    cfg_write(32'd0);
    run_delay("R5", 0, 1'b1);
    run_delay("R5", 0, 1'b0);
  endtask

  task automatic t_overrange_r3_r7;
    cfg_write(32'(DEPTH + 1));
    check("R3 readback over range", cfg_rdata, DEPTH + 1);
    run_delay("R7 depth+1", 0, 1'b1);
    cfg_write(32'h0000_00FF);
    check("R3 readback 0xFF", cfg_rdata, 255);
    run_delay("R7 0xFF", 0, 1'b0);
  endtask

  task automatic t_slave_r6;
    cfg_write(32'd3);
    master_mode = 1'b0;
    run_delay("R6 slave", 0, 1'b1);
    master_mode = 1'b1;
    run_delay("R6 back to master", 3, 1'b0);
  endtask

  task automatic t_locked_r2;
    cfg_write(32'd2);
    ctrl_enable = 1'b1;
    cfg_write(32'd4);
    check("R2 locked readback", cfg_rdata, 2);
    run_delay("R2 locked timing", 2, 1'b1);
    ctrl_enable = 1'b0;
    cfg_write(32'd4);
    check("R2 unlocked write", cfg_rdata, 4);
  endtask

  task automatic t_hold_r8;
    logic held;
    cfg_write(32'd1);
    run_delay("R8", 1, 1'b1);
    held = rx_bit;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rxd = k[0];
    end
    @(negedge clk);
    check("R8 bit held without tick", rx_bit, held);
    check("R8 no stray tick", dly_tick, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r1();
    t_field_r1();
    t_master_delays_r4();
    t_zero_r5();
    t_overrange_r3_r7();
    t_slave_r6();
    t_locked_r2();
    t_hold_r8();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule